// File: doc/BRIEF.md
# I2C Byte Shift and Receive Buffer Path

This block is the byte-level data path of an I2C controller. One shift register serializes transmit bytes onto a serial output and gathers receive bits from a serial input, one bit per strobe from the bit-level engine. Behind it sits a single receive buffer with a full flag. When the buffer is still unread, a freshly completed byte stays in the shift register until the host reads the buffer. It then moves forward on the following clock.

Frames run from one to eight bits, and the first bit on the wire is either the most significant or the least significant bit. For short frames the bit order decides which end of the register the bits sit at. The block also keeps a 7-bit own address with a format-select bit. It compares the first frame after every start condition against that address and against the general-call value. A small host register bus with a combinational read path reaches the data, own-address and control registers.

Top module: `i2c_byte_path`

## Requirements
- R1: After reset the full flag, the addressed flag and the general-call flag are 0, and the own-address register (host address 1) reads 0.
- R2: With bit order 0 (control bit 6), `ser_out` shows register bit 7 and each `bit_stb` shifts left, taking `ser_in` at bit 0. With order 1, `ser_out` shows bit 0 and each strobe shifts right, taking `ser_in` at bit 7.
- R3: A host write to the data register (address 0) loads the shift register. For a frame of N<8 bits (control bits 2:0, where 0 means 8), the transmit byte is MSB-justified under order 0 and LSB-justified under order 1.
- R4: When `frame_done` comes in receive mode (`tx_mode`=0) with the buffer empty, the received byte enters the buffer on that edge and `rx_full` becomes 1.
- R5: A received short frame appears LSB-justified under order 0 and MSB-justified under order 1, and the unused bits read 0.
- R6: If the buffer is full when a receive frame completes, the buffer keeps its byte. Reading the data register clears `rx_full`, and the waiting byte moves into the buffer on the next clock, which sets `rx_full` again.
- R7: In transmit mode (`tx_mode`=1) a completed frame never moves anything into the buffer.
- R8: While the enable bit (control bit 7) is 0, data-register writes are ignored, and data-register reads return 0 without clearing `rx_full`.
- R9: The own-address register holds the address in bits 7:1 and format-select in bit 0. It accepts writes only while the enable bit is 0.
- R10: In slave mode with format-select 0, `addr_match` is set after the first frame following `start_det` if its bits 7:1 equal the own address. Any `start_det` clears it, and with format-select 1 it is never set.
- R11: Under the same conditions, a first frame of 0x00 sets `gen_call`, and `start_det` clears it.
- R12: A data-register read in the same cycle as a receive frame completion on a full buffer returns the old byte. `rx_full` is 0 after that edge, and the new byte is in the buffer with `rx_full` 1 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 data, 1 own address, 2 control |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| bit_stb | input | 1 | Shift one bit |
| ser_in | input | 1 | Received bit |
| ser_out | output | 1 | Bit to transmit |
| start_det | input | 1 | Start condition seen |
| frame_done | input | 1 | Frame finished |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| slave_mode | input | 1 | 1 = operating as slave |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| addr_match | output | 1 | Addressed as slave |
| gen_call | output | 1 | General call received |

## Verification
The case most likely to go wrong is a host read of the buffer landing in the same clock as a receive frame completion on a full buffer. The read tries to empty the buffer while the new byte decides whether it may enter. The bench provokes this by raising `frame_done` and a data-register read together. It judges the result by three things: the read value must be the old byte, `rx_full` must be low for exactly one cycle, and the next read must return the new byte. This confirms that the byte neither overwrites the buffer during the read nor gets lost.

// File: rtl/i2c_bp_pkg.sv
package i2c_bp_pkg;
   localparam int HOST_AW = 2;
   typedef enum logic [HOST_AW-1:0] {
      REG_DATA = 2'd0,
      REG_OWN  = 2'd1,
      REG_CTRL = 2'd2,
      REG_NONE = 2'd3
   } bp_reg_e;
endpackage

// File: rtl/i2c_bp_shifter.sv
module i2c_bp_shifter #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   input  logic          shift,
   input  logic          lsb_first,
   input  logic          sin,
   output logic [DW-1:0] sreg,
   output logic          sout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sreg <= '0;
      else if (load)
         sreg <= load_data;
      else if (shift)
         sreg <= lsb_first ? {sin, sreg[DW-1:1]} : {sreg[DW-2:0], sin};
   end

   assign sout = lsb_first ? sreg[0] : sreg[DW-1];
endmodule

// File: rtl/i2c_bp_rxbuf.sv
module i2c_bp_rxbuf #(
   parameter int DW = 8,
   localparam int LW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_rx,
   input  logic          rd_take,
   input  logic [LW-1:0] len,
   input  logic          lsb_first,
   input  logic [DW-1:0] sreg,
   output logic [DW-1:0] rbuf,
   output logic          full,
   output logic          pend
);
   logic [DW-1:0] keep_mask;
   logic          xfer;
   int            nbits;

   always_comb begin
      nbits = (len == '0) ? DW : int'(len);
      for (int i = 0; i < DW; i++)
         keep_mask[i] = lsb_first ? (i >= DW - nbits) : (i < nbits);
   end

   assign xfer = (frame_rx | pend) & ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbuf <= '0;
         full <= 1'b0;
         pend <= 1'b0;
      end else begin
         if (xfer) begin
            rbuf <= sreg & keep_mask;
            full <= 1'b1;
            pend <= 1'b0;
         end else begin
            if (rd_take)
               full <= 1'b0;
            if (frame_rx && full)
               pend <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2c_bp_addrchk.sv
module i2c_bp_addrchk #(
   parameter int DW      = 8,
   parameter bit GCALL_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          frame_end,
   input  logic          enable,
   input  logic          slave,
   input  logic          fs,
   input  logic [DW-2:0] own,
   input  logic [DW-1:0] sreg,
   output logic          match,
   output logic          gcall
);
   logic first_q;
   logic judge;
   logic gc_hit;

   assign judge = frame_end & first_q & enable & slave & ~fs;

   generate
      if (GCALL_EN) begin : g_gc
         assign gc_hit = (sreg == '0);
      end else begin : g_nogc
         assign gc_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b0;
         match   <= 1'b0;
         gcall   <= 1'b0;
      end else if (start) begin
         first_q <= 1'b1;
         match   <= 1'b0;
         gcall   <= 1'b0;
      end else if (frame_end) begin
         first_q <= 1'b0;
         if (judge) begin
            match <= (sreg[DW-1:1] == own);
            gcall <= gc_hit;
         end
      end
   end
endmodule

// File: rtl/i2c_byte_path.sv
module i2c_byte_path
   import i2c_bp_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter bit GCALL_EN = 1'b1,
   localparam int LEN_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              bit_stb,
   input  logic              ser_in,
   output logic              ser_out,
   input  logic              start_det,
   input  logic              frame_done,
   input  logic              tx_mode,
   input  logic              slave_mode,
   output logic              rx_full,
   output logic              addr_match,
   output logic              gen_call
);
   initial begin
      assert (DATA_W >= 4 && (1 << LEN_W) == DATA_W)
         else $error("DATA_W must be a power of two and at least 4");
   end

   bp_reg_e            reg_sel;
   logic               en_q, order_q, fs_q;
   logic [LEN_W-1:0]   len_q;
   logic [DATA_W-2:0]  own_q;
   logic [DATA_W-1:0]  own_w, sreg_w, rbuf_w;
   logic               pend_w, rd_take, ld_data, wr_own, wr_ctrl;

   assign reg_sel = bp_reg_e'(host_addr);
   assign rd_take = host_sel & ~host_wr & (reg_sel == REG_DATA) & en_q;
   assign ld_data = host_sel &  host_wr & (reg_sel == REG_DATA) & en_q;
   assign wr_own  = host_sel &  host_wr & (reg_sel == REG_OWN)  & ~en_q;
   assign wr_ctrl = host_sel &  host_wr & (reg_sel == REG_CTRL);
   assign own_w   = {own_q, fs_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         order_q <= 1'b0;
         len_q   <= '0;
         own_q   <= '0;
         fs_q    <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            en_q    <= host_wdata[DATA_W-1];
            order_q <= host_wdata[DATA_W-2];
            len_q   <= host_wdata[LEN_W-1:0];
         end
         if (wr_own) begin
            own_q <= host_wdata[DATA_W-1:1];
            fs_q  <= host_wdata[0];
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      case (reg_sel)
         REG_DATA: host_rdata = en_q ? rbuf_w : '0;
         REG_OWN:  host_rdata = own_w;
         REG_CTRL: begin
            host_rdata[DATA_W-1]   = en_q;
            host_rdata[DATA_W-2]   = order_q;
            host_rdata[LEN_W-1:0]  = len_q;
         end
         default:  host_rdata = '0;
      endcase
   end

   i2c_bp_shifter #(.DW(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(ld_data), .load_data(host_wdata),
      .shift(bit_stb), .lsb_first(order_q), .sin(ser_in),
      .sreg(sreg_w), .sout(ser_out)
   );

   i2c_bp_rxbuf #(.DW(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .frame_rx(frame_done & ~tx_mode),
      .rd_take(rd_take), .len(len_q), .lsb_first(order_q), .sreg(sreg_w),
      .rbuf(rbuf_w), .full(rx_full), .pend(pend_w)
   );

   i2c_bp_addrchk #(.DW(DATA_W), .GCALL_EN(GCALL_EN)) u_addr (
      .clk(clk), .rst_n(rst_n), .start(start_det), .frame_end(frame_done),
      .enable(en_q), .slave(slave_mode), .fs(fs_q), .own(own_q),
      .sreg(sreg_w), .match(addr_match), .gcall(gen_call)
   );
endmodule

// File: rtl/i2c_byte_path_chk.sv
module i2c_byte_path_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frame_done,
   input logic          tx_mode,
   input logic          slave_mode,
   input logic          rx_full,
   input logic          pend,
   input logic          rd_take,
   input logic [DW-1:0] rbuf,
   input logic          host_sel,
   input logic          host_wr,
   input logic [1:0]    host_addr,
   input logic          en_q,
   input logic          fs_q,
   input logic [DW-1:0] own_reg,
   input logic          addr_match
);
   // R4
   full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> ($past(frame_done & ~tx_mode) || $past(pend)));

   // R6
   hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done & ~tx_mode & rx_full & ~rd_take) |=> (rx_full && $stable(rbuf)));

   // R7
   tx_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done & tx_mode & ~rx_full & ~pend) |=> !rx_full);

   // R9
   own_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel & host_wr & (host_addr == 2'd1) & en_q) |=> $stable(own_reg));

   // R10
   match_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_match) |-> $past(slave_mode & ~fs_q & frame_done));

   // R12
   collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done & ~tx_mode & rx_full & rd_take) |=> (!rx_full && pend));
endmodule

bind i2c_byte_path i2c_byte_path_chk #(.DW(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .tx_mode(tx_mode),
   .slave_mode(slave_mode), .rx_full(rx_full), .pend(pend_w),
   .rd_take(rd_take), .rbuf(rbuf_w), .host_sel(host_sel), .host_wr(host_wr),
   .host_addr(host_addr), .en_q(en_q), .fs_q(fs_q), .own_reg(own_w),
   .addr_match(addr_match)
);

// File: tb/i2c_byte_path_bench.sv
`timescale 1ns/1ps
module i2c_byte_path_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0, host_wr = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       bit_stb = 1'b0, ser_in = 1'b0, ser_out;
   logic       start_det = 1'b0, frame_done = 1'b0, tx_mode = 1'b0, slave_mode = 1'b0;
   logic       rx_full, addr_match, gen_call;
   int         n_chk = 0, n_bad = 0;
   logic [7:0] rv;

   always #10 clk = ~clk;

   i2c_byte_path u_i2c_byte_path (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .bit_stb(bit_stb), .ser_in(ser_in), .ser_out(ser_out),
      .start_det(start_det), .frame_done(frame_done), .tx_mode(tx_mode),
      .slave_mode(slave_mode), .rx_full(rx_full), .addr_match(addr_match),
      .gen_call(gen_call)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic host_write(input logic [1:0] a, input logic [7:0] d);
      host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      tick();
      host_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [1:0] a, output logic [7:0] d);
      host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
      #5 d = host_rdata;
      tick();
      host_sel = 1'b0;
   endtask

   task automatic shift_bit(input logic b);
      ser_in = b; bit_stb = 1'b1;
      tick();
      bit_stb = 1'b0;
   endtask

   task automatic end_frame();
      frame_done = 1'b1;
      tick();
      frame_done = 1'b0;
   endtask

   task automatic rx_byte8(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) shift_bit(b[i]);
      end_frame();
   endtask

   task automatic pulse_start();
      start_det = 1'b1;
      tick();
      start_det = 1'b0;
   endtask

   task automatic t_reset();
      check(rx_full == 1'b0, "R1 full", rx_full, 0);
      check(addr_match == 1'b0, "R1 match", addr_match, 0);
      check(gen_call == 1'b0, "R1 gcall", gen_call, 0);
      host_read(2'd1, rv);
      check(rv == 8'h00, "R1 own reset", rv, 0);
   endtask

   task automatic t_own_lock();
      host_write(2'd1, 8'h54);
      host_read(2'd1, rv);
      check(rv == 8'h54, "R9 write disabled", rv, 8'h54);
      host_write(2'd2, 8'h80);
      host_write(2'd1, 8'h12);
      host_read(2'd1, rv);
      check(rv == 8'h54, "R9 write enabled ignored", rv, 8'h54);
   endtask

   task automatic t_tx_msb();
      logic [7:0] exp = 8'hA5;
      tx_mode = 1'b1;
      host_write(2'd2, 8'h80);
      host_write(2'd0, exp);
      for (int i = 7; i >= 0; i--) begin
         check(ser_out == exp[i], "R2 msb-first bit", ser_out, exp[i]);
         shift_bit(1'b0);
      end
      end_frame();
   endtask

   task automatic t_tx_short();
      host_write(2'd2, 8'h83);
      host_write(2'd0, 8'hA0);
      check(ser_out == 1'b1, "R3 msb-just b0", ser_out, 1); shift_bit(1'b0);
      check(ser_out == 1'b0, "R3 msb-just b1", ser_out, 0); shift_bit(1'b0);
      check(ser_out == 1'b1, "R3 msb-just b2", ser_out, 1); shift_bit(1'b0);
      end_frame();
      host_write(2'd2, 8'hC3);
      host_write(2'd0, 8'h05);
      check(ser_out == 1'b1, "R3 lsb-just b0", ser_out, 1); shift_bit(1'b0);
      check(ser_out == 1'b0, "R3 lsb-just b1", ser_out, 0); shift_bit(1'b0);
      check(ser_out == 1'b1, "R3 lsb-just b2", ser_out, 1); shift_bit(1'b0);
      end_frame();
   endtask

   task automatic t_tx_no_move();
      tx_mode = 1'b1;
      host_write(2'd2, 8'h80);
      host_write(2'd0, 8'h77);
      for (int i = 0; i < 8; i++) shift_bit(1'b1);
      end_frame();
      check(rx_full == 1'b0, "R7 tx frame", rx_full, 0);
      tick();
      check(rx_full == 1'b0, "R7 tx frame later", rx_full, 0);
      tx_mode = 1'b0;
   endtask

   task automatic t_rx_short();
      tx_mode = 1'b0;
      host_write(2'd2, 8'h84);
      host_write(2'd0, 8'hFF);
      shift_bit(1); shift_bit(0); shift_bit(1); shift_bit(1);
      check(rx_full == 1'b0, "R4 before done", rx_full, 0);
      end_frame();
      check(rx_full == 1'b1, "R4 full set", rx_full, 1);
      host_read(2'd0, rv);
      check(rv == 8'h0B, "R5 lsb-justified", rv, 8'h0B);
      check(rx_full == 1'b0, "R6 read clears", rx_full, 0);
      host_write(2'd2, 8'hC4);
      shift_bit(1); shift_bit(0); shift_bit(1); shift_bit(1);
      end_frame();
      host_read(2'd0, rv);
      check(rv == 8'hD0, "R5 msb-justified", rv, 8'hD0);
   endtask

   task automatic t_hold();
      host_write(2'd2, 8'h80);
      rx_byte8(8'h3C);
      rx_byte8(8'hC3);
      check(rx_full == 1'b1, "R6 still full", rx_full, 1);
      host_read(2'd0, rv);
      check(rv == 8'h3C, "R6 old byte kept", rv, 8'h3C);
      check(rx_full == 1'b0, "R6 clear after read", rx_full, 0);
      tick();
      check(rx_full == 1'b1, "R6 refill", rx_full, 1);
      host_read(2'd0, rv);
      check(rv == 8'hC3, "R6 waiting byte", rv, 8'hC3);
   endtask

   task automatic t_collide();
      rx_byte8(8'h11);
      for (int i = 7; i >= 0; i--) shift_bit(8'h22 >> i);
      frame_done = 1'b1;
      host_sel = 1'b1; host_wr = 1'b0; host_addr = 2'd0;
      #5 rv = host_rdata;
      tick();
      frame_done = 1'b0; host_sel = 1'b0;
      check(rv == 8'h11, "R12 read old", rv, 8'h11);
      check(rx_full == 1'b0, "R12 gap", rx_full, 0);
      tick();
      check(rx_full == 1'b1, "R12 refill", rx_full, 1);
      host_read(2'd0, rv);
      check(rv == 8'h22, "R12 new byte", rv, 8'h22);
   endtask

   task automatic t_disabled();
      host_write(2'd2, 8'h80);
      rx_byte8(8'h5A);
      host_write(2'd2, 8'h00);
      host_read(2'd0, rv);
      check(rv == 8'h00, "R8 read zero", rv, 0);
      check(rx_full == 1'b1, "R8 full kept", rx_full, 1);
      host_write(2'd0, 8'hFF);
      check(ser_out == 1'b0, "R8 write ignored", ser_out, 0);
      host_write(2'd2, 8'h80);
      host_read(2'd0, rv);
      check(rv == 8'h5A, "R8 byte intact", rv, 8'h5A);
   endtask

   task automatic t_match();
      host_write(2'd2, 8'h00);
      host_write(2'd1, 8'h54);
      host_write(2'd2, 8'h80);
      slave_mode = 1'b1;
      pulse_start(); rx_byte8(8'h55);
      check(addr_match == 1'b1, "R10 match", addr_match, 1);
      check(gen_call == 1'b0, "R11 no gcall", gen_call, 0);
      host_read(2'd0, rv);
      pulse_start();
      check(addr_match == 1'b0, "R10 start clears", addr_match, 0);
      rx_byte8(8'h56);
      check(addr_match == 1'b0, "R10 mismatch", addr_match, 0);
      host_read(2'd0, rv);
      pulse_start(); rx_byte8(8'h00);
      check(gen_call == 1'b1, "R11 gcall", gen_call, 1);
      check(addr_match == 1'b0, "R11 no match", addr_match, 0);
      host_read(2'd0, rv);
      pulse_start();
      check(gen_call == 1'b0, "R11 start clears", gen_call, 0);
      host_write(2'd2, 8'h00);
      host_write(2'd1, 8'h55);
      host_write(2'd2, 8'h80);
      rx_byte8(8'h55);
      check(addr_match == 1'b0, "R10 fs=1 no match", addr_match, 0);
      host_read(2'd0, rv);
      slave_mode = 1'b0;
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_own_lock();
      t_tx_msb();
      t_tx_short();
      t_tx_no_move();
      t_rx_short();
      t_hold();
      t_collide();
      t_disabled();
      t_match();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule